// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data between memory locations on behalf of two independent channels. Each request pulse on a channel moves exactly one 8-bit or 16-bit unit. The controller takes the bus for a read phase and then a write phase, and hands the bus back before it serves the next request. When both channels are waiting, channel 0 is served first.

Each channel holds the following state:
- a source pointer and a destination pointer;
- a running "walk" pointer that advances through memory;
- a live unit counter and the value it is reloaded from;
- a control word that sets enable, unit size, repeat mode and which side walks.

Only one side of a transfer may advance. The other side stays on its pointer. Software programs the channel through a small register port. Hardware clears the enable bit when a single-mode block ends. A repeat-mode block reloads itself and keeps running until software disables it.

The controller does not reload the walk pointer or the counter at the moment of enabling. Both are loaded by the first transfer after enable is set. Each time the counter passes below zero, the channel raises a one-cycle interrupt pulse.

Top module: `dual_dma_steal`

## Requirements
- R1: After reset, every channel register reads 0. `m_valid` and `irq` are low.
- R2: Register select is `reg_addr[2:0]` and the channel index is `reg_addr[3]`. The selects are:
  - 0: source pointer (read/write);
  - 1: destination pointer (read/write);
  - 2: walk pointer (read-only);
  - 3: reload value (read/write);
  - 4: live counter (read-only);
  - 5: control, with bit0 enable, bit1 16-bit unit, bit2 repeat, and bits4:3 walk side (00 neither, 01 source, 10 destination).
  A write of walk side 11 is stored as 00. Writes to the read-only selects have no effect.
- R3: One request moves one unit. The controller reads from the source address, then writes the read data to the destination address. After the write, `m_valid` is low for at least one cycle.
- R4: An 8-bit unit writes one byte. A 16-bit unit writes two bytes, little-endian. The walk pointer advances by 1 or by 2 per transfer.
- R5: The side that is not walking uses its own pointer unchanged on every transfer. The walking side uses the walk pointer.
- R6: Setting enable from 0 to 1 leaves the walk pointer and the counter unchanged. The first transfer afterwards takes its walking address from the base pointer and its count from the reload value.
- R7: In single mode, a reload value N gives N+1 transfers. On the last transfer the counter wraps to all ones and enable clears. Later requests move nothing.
- R8: In repeat mode, the underflowing transfer sets the counter back to the reload value and the walk pointer back to the base pointer, and the channel stays enabled.
- R9: The underflowing transfer raises `irq` of its channel for exactly one cycle, in the cycle after its write handshake.
- R10: When both channels have a request waiting, channel 0 is transferred first.
- R11: Requests on a channel whose enable is 0 cause no bus activity.
- R12: A request that arrives during a transfer on the same channel is held and served afterwards, exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | {channel, select} |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data (combinational) |
| dma_req | input | 2 | Per-channel request pulses |
| m_valid | output | 1 | Bus phase active |
| m_write | output | 1 | 1 = write phase, 0 = read phase |
| m_size16 | output | 1 | Unit is 16 bits |
| m_addr | output | 20 | Bus byte address |
| m_wdata | output | 16 | Write data |
| m_rdata | input | 16 | Read data |
| m_ready | input | 1 | Phase completes this cycle |
| irq | output | 2 | Per-channel underflow pulse |

## Verification
The hardest situation to reach from the ports is a second request on a channel whose transfer is already underway. The pulse must land in the read phase, after the grant has cleared the first request and before the write completes. The stimulus places the second pulse exactly two cycles after the first, which puts it in that window. The bench then checks that exactly two writes occur and that the counter dropped by two. A second hard case is a repeat-mode underflow. The bench drives enough requests to pass zero and then reads the counter and the walk pointer back to confirm both were reloaded, not wrapped.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [1:0] {
      WALK_NONE = 2'd0,
      WALK_SRC  = 2'd1,
      WALK_DST  = 2'd2
   } walk_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RD   = 2'd1,
      PH_WR   = 2'd2
   } phase_e;

   localparam logic [2:0] SEL_SRC  = 3'd0;
   localparam logic [2:0] SEL_DST  = 3'd1;
   localparam logic [2:0] SEL_WALK = 3'd2;
   localparam logic [2:0] SEL_RLD  = 3'd3;
   localparam logic [2:0] SEL_CNT  = 3'd4;
   localparam logic [2:0] SEL_CTRL = 3'd5;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
   import dma_pkg::*;
#(
   parameter int AW = 20,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_sel,
   input  logic [AW-1:0] wr_data,
   input  logic [2:0]    rd_sel,
   output logic [AW-1:0] rd_data,
   input  logic          req,
   input  logic          start,
   output logic          ready_o,
   output logic [AW-1:0] src_o,
   output logic [AW-1:0] dst_o,
   output logic          size16_o,
   output logic          last_o
);
   logic [AW-1:0] src_q, dst_q, walk_q, base, walk_eff, step;
   logic [CW-1:0] rld_q, cnt_q, cnt_eff;
   logic          en_q, sz_q, rpt_q, need_q, pend_q, ctrl_wr;
   walk_e         walk_q_sel;

   assign base     = (walk_q_sel == WALK_DST) ? dst_q : src_q;
   assign walk_eff = need_q ? base : walk_q;
   assign cnt_eff  = need_q ? rld_q : cnt_q;
   assign step     = {{(AW-2){1'b0}}, sz_q, ~sz_q};
   assign last_o   = (cnt_eff == '0);
   assign src_o    = (walk_q_sel == WALK_SRC) ? walk_eff : src_q;
   assign dst_o    = (walk_q_sel == WALK_DST) ? walk_eff : dst_q;
   assign size16_o = sz_q;
   assign ready_o  = pend_q & en_q;
   assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0; dst_q <= '0; walk_q <= '0; rld_q <= '0; cnt_q <= '0;
         en_q <= 1'b0; sz_q <= 1'b0; rpt_q <= 1'b0; need_q <= 1'b0;
         pend_q <= 1'b0; walk_q_sel <= WALK_NONE;
      end else begin
         pend_q <= (pend_q & ~start) | (req & en_q);
         if (start) begin
            need_q <= 1'b0;
            if (last_o && rpt_q) begin
               cnt_q  <= rld_q;
               walk_q <= base;
            end else begin
               cnt_q  <= cnt_eff - 1'b1;
               walk_q <= walk_eff + step;
            end
            if (last_o && !rpt_q) begin
               en_q   <= 1'b0;
               pend_q <= 1'b0;
            end
         end
         if (wr_en) begin
            case (wr_sel)
               SEL_SRC: src_q <= wr_data;
               SEL_DST: dst_q <= wr_data;
               SEL_RLD: rld_q <= wr_data[CW-1:0];
               default: ;
            endcase
         end
         if (ctrl_wr) begin
            en_q       <= wr_data[0];
            sz_q       <= wr_data[1];
            rpt_q      <= wr_data[2];
            walk_q_sel <= (wr_data[4:3] == 2'b11) ? WALK_NONE : walk_e'(wr_data[4:3]);
            if (wr_data[0] && !en_q) need_q <= 1'b1;
            if (!wr_data[0]) pend_q <= 1'b0;
         end
      end
   end

   always_comb begin
      case (rd_sel)
         SEL_SRC:  rd_data = src_q;
         SEL_DST:  rd_data = dst_q;
         SEL_WALK: rd_data = walk_q;
         SEL_RLD:  rd_data = {{(AW-CW){1'b0}}, rld_q};
         SEL_CNT:  rd_data = {{(AW-CW){1'b0}}, cnt_q};
         SEL_CTRL: rd_data = {{(AW-5){1'b0}}, walk_q_sel, rpt_q, sz_q, en_q};
         default:  rd_data = '0;
      endcase
   end

   AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> en_q) else $error("grant on disabled channel"); // R11
   AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && last_o && !rpt_q && !ctrl_wr) |=> !en_q) else $error("single block did not stop"); // R7
   AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (start && last_o && rpt_q) |=> (cnt_q == $past(rld_q))) else $error("repeat reload missing"); // R8
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           idle,
   input  logic [NCH-1:0] ready,
   output logic [NCH-1:0] gnt
);
   always_comb begin
      logic found;
      found = 1'b0;
      gnt   = '0;
      for (int i = 0; i < NCH; i++) begin
         if (idle && ready[i] && !found) begin
            gnt[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)) else $error("multiple grants"); // R10
   AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ready[0] && (gnt != '0)) |-> gnt[0]) else $error("channel 0 lost arbitration"); // R10
endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_pkg::*;
#(
   parameter int AW   = 20,
   parameter int NCH  = 2,
   parameter int CH_W = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [CH_W-1:0] g_ch,
   input  logic [AW-1:0]   g_src,
   input  logic [AW-1:0]   g_dst,
   input  logic            g_sz,
   input  logic            g_last,
   output logic            idle_o,
   output logic            m_valid,
   output logic            m_write,
   output logic            m_size16,
   output logic [AW-1:0]   m_addr,
   output logic [15:0]     m_wdata,
   input  logic [15:0]     m_rdata,
   input  logic            m_ready,
   output logic [NCH-1:0]  irq_o
);
   phase_e          ph_q;
   logic [AW-1:0]   src_q, dst_q;
   logic            sz_q, last_q;
   logic [CH_W-1:0] ch_q;
   logic [15:0]     data_q;

   assign idle_o   = (ph_q == PH_IDLE);
   assign m_valid  = (ph_q != PH_IDLE);
   assign m_write  = (ph_q == PH_WR);
   assign m_size16 = sz_q;
   assign m_addr   = (ph_q == PH_WR) ? dst_q : src_q;
   assign m_wdata  = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_IDLE; src_q <= '0; dst_q <= '0; sz_q <= 1'b0;
         last_q <= 1'b0; ch_q <= '0; data_q <= '0; irq_o <= '0;
      end else begin
         irq_o <= '0;
         case (ph_q)
            PH_IDLE: if (go) begin
               src_q <= g_src; dst_q <= g_dst; sz_q <= g_sz;
               last_q <= g_last; ch_q <= g_ch; ph_q <= PH_RD;
            end
            PH_RD: if (m_ready) begin
               data_q <= m_rdata;
               ph_q   <= PH_WR;
            end
            PH_WR: if (m_ready) begin
               ph_q <= PH_IDLE;
               for (int i = 0; i < NCH; i++)
                  if (ch_q == CH_W'(i)) irq_o[i] <= last_q;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   AST_HANDBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_write && m_ready) |=> !m_valid) else $error("bus not handed back"); // R3
   AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_write && m_ready) |=> (m_valid && m_write)) else $error("write phase missing"); // R3
endmodule

// File: rtl/dual_dma_steal.sv
module dual_dma_steal #(
   parameter int AW  = 20,
   parameter int CW  = 16,
   parameter int NCH = 2,
   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [CH_W+2:0] reg_addr,
   input  logic [AW-1:0]   reg_wdata,
   output logic [AW-1:0]   reg_rdata,
   input  logic [NCH-1:0]  dma_req,
   output logic            m_valid,
   output logic            m_write,
   output logic            m_size16,
   output logic [AW-1:0]   m_addr,
   output logic [15:0]     m_wdata,
   input  logic [15:0]     m_rdata,
   input  logic            m_ready,
   output logic [NCH-1:0]  irq
);
   if (AW <= CW || AW < 6) begin : g_bad_aw
      $error("AW must exceed CW and be at least 6");
   end
   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("NCH must be 1..8");
   end

   logic [NCH-1:0] ready, gnt, last_a, sz_a;
   logic [AW-1:0]  src_a [NCH];
   logic [AW-1:0]  dst_a [NCH];
   logic [AW-1:0]  rd_a  [NCH];
   logic           idle, sel_sz, sel_last;
   logic [AW-1:0]  sel_src, sel_dst;
   logic [CH_W-1:0] sel_ch;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma_chan #(.AW(AW), .CW(CW)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .wr_en(reg_we && (reg_addr[CH_W+2:3] == CH_W'(i))),
         .wr_sel(reg_addr[2:0]), .wr_data(reg_wdata),
         .rd_sel(reg_addr[2:0]), .rd_data(rd_a[i]),
         .req(dma_req[i]), .start(gnt[i]), .ready_o(ready[i]),
         .src_o(src_a[i]), .dst_o(dst_a[i]),
         .size16_o(sz_a[i]), .last_o(last_a[i])
      );
   end

   dma_arb #(.NCH(NCH)) u_arb (
      .clk(clk), .rst_n(rst_n), .idle(idle), .ready(ready), .gnt(gnt)
   );

   always_comb begin
      sel_src = '0; sel_dst = '0; sel_sz = 1'b0; sel_last = 1'b0; sel_ch = '0;
      reg_rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (gnt[i]) begin
            sel_src = src_a[i]; sel_dst = dst_a[i];
            sel_sz = sz_a[i]; sel_last = last_a[i]; sel_ch = CH_W'(i);
         end
         if (reg_addr[CH_W+2:3] == CH_W'(i)) reg_rdata = rd_a[i];
      end
   end

   dma_seq #(.AW(AW), .NCH(NCH), .CH_W(CH_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(|gnt), .g_ch(sel_ch),
      .g_src(sel_src), .g_dst(sel_dst), .g_sz(sel_sz), .g_last(sel_last),
      .idle_o(idle), .m_valid(m_valid), .m_write(m_write), .m_size16(m_size16),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready),
      .irq_o(irq)
   );

   AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq)) else $error("two interrupts at once"); // R9
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq != '0) |=> (irq == '0)) else $error("interrupt longer than a cycle"); // R9
endmodule

// File: tb/dual_dma_steal_tb.sv
module dual_dma_steal_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [19:0] reg_wdata = '0;
   logic [19:0] reg_rdata;
   logic [1:0]  dma_req = '0;
   logic        m_valid, m_write, m_size16;
   logic [19:0] m_addr;
   logic [15:0] m_wdata, m_rdata;
   logic        m_ready = 1'b1;
   logic [1:0]  irq;

   int n_tot = 0, n_bad = 0, n_wr = 0, n_long = 0;
   int n_irq [2];
   logic [7:0]  mem [256];
   logic [19:0] wr_log [16];
   logic [19:0] last_rd;
   logic [1:0]  irq_prev = '0;

   always #2.5 clk = ~clk;

   dual_dma_steal u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
      .m_valid(m_valid), .m_write(m_write), .m_size16(m_size16),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
      .m_ready(m_ready), .irq(irq)
   );

   assign m_rdata = {mem[m_addr[7:0] + 8'd1], mem[m_addr[7:0]]};

   always @(posedge clk) begin
      if (m_valid && m_ready) begin
         if (m_write) begin
            mem[m_addr[7:0]] <= m_wdata[7:0];
            if (m_size16) mem[m_addr[7:0] + 8'd1] <= m_wdata[15:8];
            wr_log[n_wr % 16] <= m_addr;
            n_wr <= n_wr + 1;
         end else last_rd <= m_addr;
      end
      for (int i = 0; i < 2; i++) begin
         if (irq[i]) n_irq[i] <= n_irq[i] + 1;
         if (irq[i] && irq_prev[i]) n_long <= n_long + 1;
      end
      irq_prev <= irq;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tot++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wreg(input int ch, input int sel, input logic [19:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = {ch[0], sel[2:0]}; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rreg(input int ch, input int sel, output logic [19:0] v);
      @(negedge clk);
      reg_addr = {ch[0], sel[2:0]};
      #1 v = reg_rdata;
   endtask

   task automatic pulse(input logic [1:0] m);
      @(negedge clk); dma_req = m;
      @(negedge clk); dma_req = '0;
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [19:0] v;
      chk("R1 m_valid", {31'b0, m_valid}, 0);
      chk("R1 irq", {30'b0, irq}, 0);
      rreg(0, 5, v); chk("R1 ctrl0", {12'b0, v}, 0);
      rreg(1, 4, v); chk("R1 cnt1", {12'b0, v}, 0);
      rreg(0, 2, v); chk("R1 walk0", {12'b0, v}, 0);
   endtask

   task automatic t_regs;
      logic [19:0] v;
      wreg(1, 0, 20'h12345); rreg(1, 0, v); chk("R2 src", {12'b0, v}, 32'h12345);
      wreg(1, 1, 20'hABCDE); rreg(1, 1, v); chk("R2 dst", {12'b0, v}, 32'hABCDE);
      wreg(1, 3, 20'h01234); rreg(1, 3, v); chk("R2 reload", {12'b0, v}, 32'h1234);
      wreg(1, 2, 20'h00777); rreg(1, 2, v); chk("R2 walk ro", {12'b0, v}, 0);
      wreg(1, 4, 20'h00555); rreg(1, 4, v); chk("R2 cnt ro", {12'b0, v}, 0);
      wreg(1, 5, 20'h0001E); rreg(1, 5, v); chk("R2 walk11", {12'b0, v}, 32'h06);
   endtask

   task automatic t_single8;
      logic [19:0] v;
      int w0;
      wreg(0, 0, 20'h00010); wreg(0, 1, 20'h00080); wreg(0, 3, 20'd2);
      wreg(0, 5, 20'h00008);
      w0 = n_wr; pulse(2'b01); waitc(8);
      chk("R11 disabled req", n_wr, w0);
      wreg(0, 5, 20'h00009);
      rreg(0, 4, v); chk("R6 cnt at enable", {12'b0, v}, 0);
      rreg(0, 2, v); chk("R6 walk at enable", {12'b0, v}, 0);
      pulse(2'b01); waitc(8);
      chk("R3 read addr", {12'b0, last_rd}, 32'h10);
      chk("R5 fixed dst", {12'b0, wr_log[w0 % 16]}, 32'h80);
      chk("R3 data", {24'b0, mem[8'h80]}, 32'h10 ^ 32'h5A);
      chk("R4 byte only", {24'b0, mem[8'h81]}, 32'h81 ^ 32'h5A);
      rreg(0, 2, v); chk("R4 R6 walk", {12'b0, v}, 32'h11);
      rreg(0, 4, v); chk("R6 cnt", {12'b0, v}, 1);
      chk("R9 no early irq", n_irq[0], 0);
      pulse(2'b01); waitc(8); pulse(2'b01); waitc(8);
      chk("R7 count N+1", n_wr - w0, 3);
      chk("R5 walk src", {24'b0, mem[8'h80]}, 32'h12 ^ 32'h5A);
      chk("R9 irq once", n_irq[0], 1);
      rreg(0, 5, v); chk("R7 enable cleared", {12'b0, v}, 32'h08);
      rreg(0, 4, v); chk("R7 cnt wraps", {12'b0, v}, 32'hFFFF);
      pulse(2'b01); waitc(8);
      chk("R7 stopped", n_wr - w0, 3);
   endtask

   task automatic t_repeat16;
      logic [19:0] v;
      int w0;
      wreg(1, 0, 20'h00020); wreg(1, 1, 20'h00040); wreg(1, 3, 20'd1);
      wreg(1, 5, 20'h00017);
      w0 = n_wr;
      pulse(2'b10); waitc(8);
      rreg(1, 2, v); chk("R4 step 2", {12'b0, v}, 32'h42);
      rreg(1, 4, v); chk("R8 cnt0", {12'b0, v}, 0);
      pulse(2'b10); waitc(8);
      chk("R4 word lo", {24'b0, mem[8'h42]}, 32'h20 ^ 32'h5A);
      chk("R4 word hi", {24'b0, mem[8'h43]}, 32'h21 ^ 32'h5A);
      rreg(1, 4, v); chk("R8 cnt reload", {12'b0, v}, 1);
      rreg(1, 2, v); chk("R8 walk reload", {12'b0, v}, 32'h40);
      rreg(1, 5, v); chk("R8 still enabled", {31'b0, v[0]}, 1);
      chk("R9 ch1 irq", n_irq[1], 1);
      pulse(2'b10); waitc(8);
      chk("R8 restart addr", {12'b0, wr_log[(w0 + 2) % 16]}, 32'h40);
      chk("R5 fixed src", {12'b0, last_rd}, 32'h20);
      wreg(1, 5, 20'h00016);
      pulse(2'b10); waitc(8);
      chk("R11 sw disable", n_wr - w0, 3);
   endtask

   task automatic t_prio;
      int w0;
      wreg(0, 0, 20'h00030); wreg(0, 1, 20'h00090); wreg(0, 3, 20'd5);
      wreg(0, 5, 20'h00001);
      wreg(1, 0, 20'h00031); wreg(1, 1, 20'h00091); wreg(1, 5, 20'h00001);
      w0 = n_wr;
      pulse(2'b11); waitc(12);
      chk("R10 two moves", n_wr - w0, 2);
      chk("R10 ch0 first", {12'b0, wr_log[w0 % 16]}, 32'h90);
      chk("R10 ch1 second", {12'b0, wr_log[(w0 + 1) % 16]}, 32'h91);
   endtask

   task automatic t_pending;
      logic [19:0] v;
      int w0;
      w0 = n_wr;
      @(negedge clk); dma_req = 2'b01;
      @(negedge clk); dma_req = 2'b00;
      @(negedge clk); dma_req = 2'b01;
      @(negedge clk); dma_req = 2'b00;
      waitc(12);
      chk("R12 held once", n_wr - w0, 2);
      rreg(0, 4, v); chk("R12 cnt", {12'b0, v}, 2);
      chk("R9 width", n_long, 0);
   endtask

   task automatic finish_run;
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      n_irq[0] = 0; n_irq[1] = 0;
      last_rd = '0;
      for (int i = 0; i < 16; i++) wr_log[i] = '0;
      waitc(3);
      t_reset;
      rst_n = 1'b1;
      waitc(2);
      t_regs;
      t_single8;
      t_repeat16;
      t_prio;
      t_pending;
      finish_run;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tot++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run;
   end
endmodule